// File: doc/BRIEF.md
# Variable-Length SPI Mode-0 Master

This block is an SPI master that moves one to four bytes per frame through a single 32-bit shift engine. For each transfer the client presents a 32-bit data word, a 3-bit length code and a one-cycle start pulse. A payload shorter than 32 bits sits in the upper bits of the data word. The engine always shifts from bit 31 downward, so only the bit counter decides how long the frame is.

The serial clock comes from a divider. Each low phase and each high phase of SCLK lasts `HALF_DIV` system clocks. The slave select is active low. The master drives MOSI MSB first and changes it on falling SCLK edges. It samples MISO on rising edges into an 8-bit receive shifter. The attached peripheral answers in the third byte slot, so the receive shifter's contents after the 24th rising edge are latched as the reply. A one-cycle done pulse closes every frame. A reply-valid pulse comes with it only when the frame was long enough to contain the third byte.

Top module: `spi_varlen_master`

## Requirements
- R1: After reset, and whenever no frame is running, `cs_n` is 1, `sclk` is 0 and `done` is 0. Whenever `cs_n` is 1, `sclk` is 0.
- R2: The length code sets the number of SCLK rising edges in a frame: 3'b001 gives 8, 3'b010 gives 16, 3'b011 gives 24 and 3'b100 gives 32. A start pulse with any other code (000, 101, 110, 111) leaves `cs_n` high and produces no `done`.
- R3: MOSI carries `tx_data[31]` first and then the following lower bits. A frame of N bits therefore sends `tx_data[31:32-N]`, with the most significant bit first.
- R4: SPI mode 0 holds. MOSI does not change while SCLK is high, and the slave captures it on rising edges.
- R5: The first rising SCLK edge comes `HALF_DIV` clocks after `cs_n` falls. Consecutive rising edges within a frame are `2*HALF_DIV` clocks apart.
- R6: `cs_n` stays low for the whole frame and rises on the clock of the last falling SCLK edge. In that same cycle `done` is 1, for exactly one cycle.
- R7: `reply` takes the 8 MISO bits sampled on rising edges 17 to 24 of the frame, MSB first. `reply_valid` pulses together with `done` only for 24- and 32-bit frames. For 8- and 16-bit frames it stays 0.
- R8: A start pulse during a running frame is ignored. The frame keeps its original length and data, and no second frame follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a frame |
| len_sel | input | 3 | Frame length code |
| tx_data | input | 32 | Payload, left-aligned |
| miso | input | 1 | Serial data from slave |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to slave |
| done | output | 1 | One-cycle end-of-frame pulse |
| reply | output | 8 | Byte received in the third byte slot |
| reply_valid | output | 1 | Pulses with `done` when `reply` was refreshed |

## Verification
The situation hardest to reach from the ports is a second start request arriving while a frame is half shifted out. The bench starts a 16-bit frame and then pulses start again about thirty clocks later, with a different length code and different data. It then checks that the slave still sees exactly 16 bits of the first word, that only one done pulse appears, and that no new select falls afterwards. The reply byte is observed through a slave model that shifts a known 32-bit pattern on MISO. This lets the bench check that bits from byte slots one, two and four never reach `reply`.

// File: rtl/spi_varlen_master.sv
module spi_varlen_master #(
  parameter int HALF_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [2:0]  len_sel,
  input  logic [31:0] tx_data,
  input  logic        miso,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  output logic        done,
  output logic [7:0]  reply,
  output logic        reply_valid
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DLY_LOAD = DW'(HALF_DIV - 1);

  logic          active;
  logic [31:0]   shreg;
  logic [5:0]    bits_left;
  logic [5:0]    rise_cnt;
  logic [DW-1:0] dly;
  logic [7:0]    rx_sh;
  logic [5:0]    len_bits;

  always_comb begin
    case (len_sel)
      3'b001:  len_bits = 6'd8;
      3'b010:  len_bits = 6'd16;
      3'b011:  len_bits = 6'd24;
      3'b100:  len_bits = 6'd32;
      default: len_bits = 6'd0;
    endcase
  end

  assign mosi = shreg[31];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active      <= 1'b0;
      sclk        <= 1'b0;
      cs_n        <= 1'b1;
      done        <= 1'b0;
      reply_valid <= 1'b0;
      reply       <= '0;
      rx_sh       <= '0;
      shreg       <= '0;
      bits_left   <= '0;
      rise_cnt    <= '0;
      dly         <= DLY_LOAD;
    end else begin
      done        <= 1'b0;
      reply_valid <= 1'b0;
      if (!active) begin
        sclk      <= 1'b0;
        cs_n      <= 1'b1;
        shreg     <= tx_data;
        bits_left <= len_bits;
        rise_cnt  <= '0;
        dly       <= DLY_LOAD;
        if (start && len_bits != 6'd0) begin
          active <= 1'b1;
          cs_n   <= 1'b0;
        end
      end else if (dly != '0) begin
        dly <= dly - 1'b1;
      end else begin
        dly  <= DLY_LOAD;
        sclk <= ~sclk;
        if (!sclk) begin
          rx_sh    <= {rx_sh[6:0], miso};
          rise_cnt <= rise_cnt + 6'd1;
          if (rise_cnt == 6'd23) reply <= {rx_sh[6:0], miso};
        end else begin
          shreg     <= {shreg[30:0], 1'b0};
          bits_left <= bits_left - 6'd1;
          if (bits_left == 6'd1) begin
            active      <= 1'b0;
            cs_n        <= 1'b1;
            done        <= 1'b1;
            reply_valid <= (rise_cnt >= 6'd24);
          end
        end
      end
    end
  end

  assert_idle_clock_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  assert_mosi_stable_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  assert_done_with_deselect_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $rose(cs_n));

  assert_deselect_only_at_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> done);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reply_valid_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reply_valid |-> done);
endmodule

// File: tb/spi_varlen_master_bench.sv
module spi_varlen_master_bench;
  localparam int HALF_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  len_sel = 3'b000;
  logic [31:0] tx_data = '0;
  logic        miso;
  logic        sclk, cs_n, mosi, done, reply_valid;
  logic [7:0]  reply;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  spi_varlen_master #(.HALF_DIV(HALF_DIV)) u_spi_varlen_master (
    .clk(clk), .rst_n(rst_n), .start(start), .len_sel(len_sel),
    .tx_data(tx_data), .miso(miso), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .done(done), .reply(reply), .reply_valid(reply_valid)
  );

  logic [31:0] sl_data = '0;
  logic [31:0] sl_sh = '0;
  logic [31:0] sl_rx = '0;
  int          sl_bits = 0;
  int          cs_falls = 0;
  int          done_cnt = 0;
  int          cyc = 0;
  int          last_edge = 0;
  int          first_rise = 0;
  int          period_err = 0;

  assign miso = sl_sh[31];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n && done) done_cnt = done_cnt + 1;
  end

  always @(negedge cs_n) begin
    sl_sh = sl_data;
    sl_rx = '0;
    sl_bits = 0;
    cs_falls = cs_falls + 1;
    last_edge = cyc;
    first_rise = 1;
  end

  always @(posedge sclk) begin
    sl_rx = {sl_rx[30:0], mosi};
    sl_bits = sl_bits + 1;
    if (first_rise == 1) begin
      if (cyc - last_edge != HALF_DIV) period_err = period_err + 1;
    end else if (cyc - last_edge != 2 * HALF_DIV) period_err = period_err + 1;
    first_rise = 0;
    last_edge = cyc;
  end

  always @(negedge sclk) if (!cs_n) sl_sh = {sl_sh[30:0], 1'b0};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int code_len(input logic [2:0] c);
    case (c)
      3'b001: return 8;
      3'b010: return 16;
      3'b011: return 24;
      3'b100: return 32;
      default: return 0;
    endcase
  endfunction

  task automatic pulse_start(input logic [2:0] c, input logic [31:0] d);
    @(negedge clk);
    len_sel = c; tx_data = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output bit ok, output logic [7:0] r, output logic rv);
    ok = 0; r = '0; rv = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; r = reply; rv = reply_valid; return; end
    end
  endtask

  localparam int NV = 6;
  localparam logic [66:0] VEC [NV] = '{
    {3'b001, 32'hA5_00_00_00, 32'h3C_11_22_33},
    {3'b010, 32'hC3_5A_00_00, 32'h81_7E_44_55},
    {3'b011, 32'h12_34_56_00, 32'hF0_0F_9B_66},
    {3'b100, 32'hDE_AD_BE_EF, 32'h01_02_C7_04},
    {3'b011, 32'hFF_00_FF_77, 32'h00_FF_5E_AA},
    {3'b100, 32'h80_00_00_01, 32'hAA_55_E1_3C}
  };

  initial begin
    repeat (3) @(negedge clk);
    check("R1 cs_n at reset", {31'd0, cs_n}, 32'd1);
    check("R1 sclk at reset", {31'd0, sclk}, 32'd0);
    check("R1 done at reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle after reset", {30'd0, cs_n, sclk}, 32'd2);

    for (int v = 0; v < NV; v++) begin
      logic [2:0] c; logic [31:0] d; int n; bit ok; logic [7:0] r; logic rv;
      int d0;
      c = VEC[v][66:64]; d = VEC[v][63:32]; sl_data = VEC[v][31:0];
      n = code_len(c);
      d0 = done_cnt;
      pulse_start(c, d);
      wait_done(ok, r, rv);
      check("R6 done seen", {31'd0, ok}, 32'd1);
      check("R6 cs_n high at done", {31'd0, cs_n}, 32'd1);
      check("R2 bit count", sl_bits, n);
      check("R3 MOSI bits", sl_rx, d >> (32 - n));
      check("R7 reply_valid", {31'd0, rv}, {31'd0, n >= 24});
      if (n >= 24) check("R7 reply byte", {24'd0, r}, {24'd0, sl_data[15:8]});
      @(negedge clk);
      check("R6 single done", done_cnt - d0, 1);
    end

    begin
      int f0, d0;
      f0 = cs_falls; d0 = done_cnt;
      pulse_start(3'b000, 32'hFFFF_FFFF);
      pulse_start(3'b101, 32'hFFFF_FFFF);
      pulse_start(3'b110, 32'hFFFF_FFFF);
      pulse_start(3'b111, 32'hFFFF_FFFF);
      repeat (60) @(negedge clk);
      check("R2 invalid code no select", cs_falls - f0, 0);
      check("R2 invalid code no done", done_cnt - d0, 0);
    end

    begin
      int f0, d0; bit ok; logic [7:0] r; logic rv;
      f0 = cs_falls; d0 = done_cnt;
      sl_data = 32'h5555_5555;
      pulse_start(3'b010, 32'hB7_1E_00_00);
      repeat (30) @(negedge clk);
      pulse_start(3'b100, 32'h0F0F_0F0F);
      wait_done(ok, r, rv);
      check("R8 first frame finishes", {31'd0, ok}, 32'd1);
      check("R8 length kept", sl_bits, 16);
      check("R8 data kept", sl_rx, 32'h0000_B71E);
      repeat (80) @(negedge clk);
      check("R8 no second frame", cs_falls - f0, 1);
      check("R8 one done", done_cnt - d0, 1);
    end

    check("R5 SCLK timing errors", period_err, 0);
    check("R4 idle sclk low", {31'd0, sclk}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule